// File: doc/BRIEF.md
# Host Messaging Queue Unit

This block passes 32-bit message handles between a host bus agent and a local processor through four circular queues. Two queues run toward the local processor (inbound) and two run toward the host (outbound). In each direction one queue carries posted messages and its partner returns free messages for reuse. A handle therefore travels in a loop:
- The host posts an inbound handle and the local processor consumes it. The local processor then hands it back on the inbound free queue.
- The local processor posts an outbound handle and the host consumes it. The host then returns it on the outbound free queue.

Each side has a small register port. A 3-bit address selects a queue or the status word. The queue's identity decides whether a write on that port becomes a push and whether a read becomes a pop. Accesses that the queue's direction does not allow are ignored. The host port carries byte enables. They mask the stored bytes, but they never suppress the push. Read results are registered.

The unit drives a level interrupt to the local processor while inbound posted work is waiting. It raises a pending flag toward the host while outbound posted work is waiting. Pushes to a full queue are dropped, and each queue keeps a sticky overflow flag.

Top module: `msg_queue_unit`

## Requirements
- R1: Address codes on both ports are 0 = inbound post, 1 = inbound free, 2 = outbound post, 3 = outbound free, 4 = status word. Each queue returns handles in the order they were pushed.
- R2: A host write to queue 1 or 2 has no effect. A host read of queue 0, 3 or any other non-status code returns 32'hFFFF_FFFF and removes nothing. The local port mirrors this: writes to queues 0 and 3 are ignored, and reads of queues 1 and 2 return all ones.
- R3: A host write to queue 0 or 3 always pushes one entry, even when every byte enable is clear. Bit k of host_be selects data byte k, and deselected bytes are stored as zero.
- R4: A host read of queue 1 or 2 pops it. A local read of queue 0 or 3 pops it. A local write to queue 1 or 2 pushes the full local data word.
- R5: A pop from an empty queue returns 32'hFFFF_FFFF and leaves that queue's pointers unchanged.
- R6: A push to a full queue is dropped. It sets that queue's sticky overflow flag, which only reset clears.
- R7: Head and tail pointers wrap modulo DEPTH, so a queue stays in order across any number of fill and drain rounds.
- R8: loc_irq is high exactly while the inbound post queue holds at least one entry. host_msg_pending is high exactly while the outbound post queue holds at least one entry.
- R9: When both ports touch the same queue in one cycle, the host access takes effect first. A local pop of an empty inbound post queue during a host push returns the pushed word. A local push to a full inbound free queue during a host pop of that queue is accepted.
- R10: The status word holds the empty flags in bits [3:0], the full flags in bits [7:4] and the overflow flags in bits [11:8], with bit offset equal to the queue code. All other bits are zero. After reset all queues are empty, both read registers are zero and both flag outputs are low.
- R11: Read data appears on the port's rdata output on the clock edge that samples the read strobe. It holds that value until the next read on the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host queue/status select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host registered read data |
| host_msg_pending | output | 1 | Outbound post queue not empty |
| loc_addr | input | 3 | Local queue/status select |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local registered read data |
| loc_irq | output | 1 | Inbound post queue not empty |

## Verification
The bench builds the unit with DEPTH = 4 and the 32-bit handle width. With that depth, a full queue, dropped pushes and pointer wrap around all occur within a handful of accesses. This also makes the same-cycle host-first ordering on a full queue easy to set up. The vector table covers the access steering of every queue code. Directed sequences then cover byte-enable masking, overflow, wrap and both port-collision orderings.

// File: rtl/mqu_pkg.sv
package mqu_pkg;

    localparam int MSG_W   = 32;
    localparam int BYTES_W = MSG_W / 8;
    localparam int NQ      = 4;

    localparam logic [MSG_W-1:0] EMPTY_WORD = '1;

    typedef enum logic [2:0] {
        Q_IN_POST  = 3'd0,
        Q_IN_FREE  = 3'd1,
        Q_OUT_POST = 3'd2,
        Q_OUT_FREE = 3'd3,
        Q_STATUS   = 3'd4
    } qsel_e;

    typedef struct packed {
        logic             push;
        logic             pop;
        logic [MSG_W-1:0] data;
    } qreq_t;

    // Queues filled from the host side; the others are drained by the host.
    function automatic logic host_fills(input int q);
        return (q == int'(Q_IN_POST)) || (q == int'(Q_OUT_FREE));
    endfunction

endpackage

// File: rtl/mqu_steer.sv
module mqu_steer
    import mqu_pkg::*;
(
    input  logic [2:0]         host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [BYTES_W-1:0] host_be,
    input  logic [MSG_W-1:0]   host_wdata,
    input  logic [2:0]         loc_addr,
    input  logic               loc_wr,
    input  logic               loc_rd,
    input  logic [MSG_W-1:0]   loc_wdata,
    output qreq_t [NQ-1:0]     req
);

    logic [MSG_W-1:0] host_masked;

    // Byte enables shape the stored word but never gate the push.
    for (genvar b = 0; b < BYTES_W; b++) begin : g_mask
        assign host_masked[b*8 +: 8] = host_be[b] ? host_wdata[b*8 +: 8] : 8'h00;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_req
        localparam logic HOST_SIDE_PUSH = host_fills(q);
        localparam logic [2:0] CODE = 3'(q);
        if (HOST_SIDE_PUSH) begin : g_host_in
            assign req[q].push = host_wr && (host_addr == CODE);
            assign req[q].pop  = loc_rd  && (loc_addr  == CODE);
            assign req[q].data = host_masked;
        end else begin : g_loc_in
            assign req[q].push = loc_wr  && (loc_addr  == CODE);
            assign req[q].pop  = host_rd && (host_addr == CODE);
            assign req[q].data = loc_wdata;
        end
    end

endmodule

// File: rtl/mqu_ring.sv
module mqu_ring
    import mqu_pkg::*;
#(
    parameter int   DEPTH      = 16,
    parameter logic PUSH_FIRST = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [MSG_W-1:0] push_data,
    input  logic             pop,
    output logic [MSG_W-1:0] pop_data,
    output logic             empty,
    output logic             full,
    output logic             ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [MSG_W-1:0] mem [DEPTH];
    logic [AW-1:0]    head, tail;
    logic [CW-1:0]    cnt, mid_cnt;
    logic             push_ok, pop_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    if (PUSH_FIRST) begin : g_push_first
        always_comb begin
            push_ok  = push && (cnt != FULL_CNT);
            mid_cnt  = cnt + CW'(push_ok);
            pop_ok   = pop && (mid_cnt != '0);
            pop_data = !pop_ok        ? EMPTY_WORD :
                       (cnt == '0)    ? push_data  : mem[tail];
        end
    end else begin : g_pop_first
        always_comb begin
            pop_ok   = pop && (cnt != '0);
            mid_cnt  = cnt - CW'(pop_ok);
            push_ok  = push && (mid_cnt != FULL_CNT);
            pop_data = pop_ok ? mem[tail] : EMPTY_WORD;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[head] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
            ovf  <= 1'b0;
        end else begin
            if (push_ok) head <= step(head);
            if (pop_ok)  tail <= step(tail);
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
            if (push && !push_ok) ovf <= 1'b1;
        end
    end

    assign empty = (cnt == '0);
    assign full  = (cnt == FULL_CNT);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (ovf && full && $stable(head)));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (empty && $stable(tail)));

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

endmodule

// File: rtl/msg_queue_unit.sv
module msg_queue_unit
    import mqu_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [BYTES_W-1:0] host_be,
    input  logic [MSG_W-1:0]   host_wdata,
    output logic [MSG_W-1:0]   host_rdata,
    output logic               host_msg_pending,
    input  logic [2:0]         loc_addr,
    input  logic               loc_wr,
    input  logic               loc_rd,
    input  logic [MSG_W-1:0]   loc_wdata,
    output logic [MSG_W-1:0]   loc_rdata,
    output logic               loc_irq
);

    qreq_t [NQ-1:0]   req;
    logic [MSG_W-1:0] qdata [NQ];
    logic [NQ-1:0]    q_empty, q_full, q_ovf;
    logic [MSG_W-1:0] status_word;

    mqu_steer u_steer (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_be   (host_be),
        .host_wdata(host_wdata),
        .loc_addr  (loc_addr),
        .loc_wr    (loc_wr),
        .loc_rd    (loc_rd),
        .loc_wdata (loc_wdata),
        .req       (req)
    );

    // Host side goes first: push-first where the host fills, pop-first where it drains.
    for (genvar q = 0; q < NQ; q++) begin : g_q
        mqu_ring #(
            .DEPTH     (DEPTH),
            .PUSH_FIRST(host_fills(q))
        ) u_ring (
            .clk      (clk),
            .rst      (rst),
            .push     (req[q].push),
            .push_data(req[q].data),
            .pop      (req[q].pop),
            .pop_data (qdata[q]),
            .empty    (q_empty[q]),
            .full     (q_full[q]),
            .ovf      (q_ovf[q])
        );
    end

    assign status_word = {{(MSG_W - 3*NQ){1'b0}}, q_ovf, q_full, q_empty};

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            case (host_addr)
                Q_IN_FREE:  host_rdata <= qdata[Q_IN_FREE];
                Q_OUT_POST: host_rdata <= qdata[Q_OUT_POST];
                Q_STATUS:   host_rdata <= status_word;
                default:    host_rdata <= EMPTY_WORD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_rdata <= '0;
        end else if (loc_rd) begin
            case (loc_addr)
                Q_IN_POST:  loc_rdata <= qdata[Q_IN_POST];
                Q_OUT_FREE: loc_rdata <= qdata[Q_OUT_FREE];
                Q_STATUS:   loc_rdata <= status_word;
                default:    loc_rdata <= EMPTY_WORD;
            endcase
        end
    end

    assign loc_irq          = !q_empty[Q_IN_POST];
    assign host_msg_pending = !q_empty[Q_OUT_POST];

    // R11
    host_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));

    // R11
    loc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !loc_rd |=> $stable(loc_rdata));

endmodule

// File: tb/msg_queue_unit_tb.sv
module msg_queue_unit_tb_top;

    localparam int DEPTH = 4;
    localparam int NV    = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_be = 4'hF;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_msg_pending;
    logic [2:0]  loc_addr = '0;
    logic        loc_wr = 1'b0, loc_rd = 1'b0;
    logic [31:0] loc_wdata = '0;
    logic [31:0] loc_rdata;
    logic        loc_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    msg_queue_unit #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_msg_pending(host_msg_pending),
        .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_rd(loc_rd),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_irq(loc_irq)
    );

    // {req[73:70], host[69], read[68], check[67], addr[66:64], data[63:32], expect[31:0]}
    localparam logic [73:0] VEC [NV] = '{
        {4'd4, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0000_00A1, 32'h0},          // R4 host post
        {4'd2, 1'b1, 1'b1, 1'b1, 3'd0, 32'h0,         32'hFFFF_FFFF},  // R2 host read of q0
        {4'd4, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0000_00A2, 32'h0},
        {4'd4, 1'b0, 1'b1, 1'b1, 3'd0, 32'h0,         32'h0000_00A1},  // R4 order
        {4'd4, 1'b0, 1'b1, 1'b1, 3'd0, 32'h0,         32'h0000_00A2},
        {4'd5, 1'b0, 1'b1, 1'b1, 3'd0, 32'h0,         32'hFFFF_FFFF},  // R5
        {4'd2, 1'b1, 1'b0, 1'b0, 3'd1, 32'h0000_0BAD, 32'h0},          // R2 ignored write
        {4'd2, 1'b1, 1'b1, 1'b1, 3'd1, 32'h0,         32'hFFFF_FFFF},
        {4'd4, 1'b0, 1'b0, 1'b0, 3'd1, 32'h0000_0011, 32'h0},
        {4'd4, 1'b1, 1'b1, 1'b1, 3'd1, 32'h0,         32'h0000_0011},
        {4'd4, 1'b0, 1'b0, 1'b0, 3'd2, 32'h0000_0022, 32'h0},
        {4'd4, 1'b1, 1'b1, 1'b1, 3'd2, 32'h0,         32'h0000_0022},
        {4'd4, 1'b1, 1'b0, 1'b0, 3'd3, 32'h0000_0033, 32'h0},
        {4'd4, 1'b0, 1'b1, 1'b1, 3'd3, 32'h0,         32'h0000_0033},
        {4'd1, 1'b0, 1'b1, 1'b1, 3'd4, 32'h0,         32'h0000_000F}   // R1 status
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with registered read data.
    task automatic host_op(input bit rd, input logic [2:0] a, input logic [3:0] be,
                           input logic [31:0] d, output logic [31:0] r);
        host_addr = a; host_be = be; host_wdata = d;
        host_wr = !rd; host_rd = rd;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; host_be = 4'hF;
        r = host_rdata;
    endtask

    task automatic loc_op(input bit rd, input logic [2:0] a, input logic [31:0] d,
                          output logic [31:0] r);
        loc_addr = a; loc_wdata = d;
        loc_wr = !rd; loc_rd = rd;
        @(negedge clk);
        loc_wr = 1'b0; loc_rd = 1'b0;
        r = loc_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check("R10 host_rdata", host_rdata, 32'h0);
        check("R10 loc_rdata", loc_rdata, 32'h0);
        check("R10 flags", {30'h0, loc_irq, host_msg_pending}, 32'h0);
        loc_op(1'b1, 3'd4, 32'h0, r);
        check("R10 status", r, 32'h0000_000F);

        for (int i = 0; i < NV; i++) begin
            logic [73:0] v;
            string tag;
            v = VEC[i];
            if (v[69]) host_op(v[68], v[66:64], 4'hF, v[63:32], r);
            else       loc_op(v[68], v[66:64], v[63:32], r);
            if (v[67]) begin
                tag = $sformatf("R%0d vec%0d", v[73:70], i);
                check(tag, r, v[31:0]);
            end
        end

        // R3 cleared byte enables still push; masked bytes stored as zero
        host_op(1'b0, 3'd0, 4'h0, 32'hDEAD_BEEF, r);
        check("R8 irq after post", {31'h0, loc_irq}, 32'h1);
        host_op(1'b0, 3'd0, 4'b0101, 32'hAABB_CCDD, r);
        loc_op(1'b1, 3'd0, 32'h0, r);
        check("R3 null be", r, 32'h0);
        loc_op(1'b1, 3'd0, 32'h0, r);
        check("R3 partial be", r, 32'h00BB_00DD);
        check("R8 irq drained", {31'h0, loc_irq}, 32'h0);

        // R8 host pending flag
        loc_op(1'b0, 3'd2, 32'h0000_0077, r);
        check("R8 pending set", {31'h0, host_msg_pending}, 32'h1);
        host_op(1'b1, 3'd2, 4'hF, 32'h0, r);
        check("R8 pending clear", {31'h0, host_msg_pending}, 32'h0);
        // R11 data holds without a read
        repeat (2) @(negedge clk);
        check("R11 hold", host_rdata, 32'h0000_0077);

        // R6 overflow on outbound free queue
        for (int k = 1; k <= DEPTH + 2; k++) host_op(1'b0, 3'd3, 4'hF, 32'(k), r);
        host_op(1'b1, 3'd4, 4'hF, 32'h0, r);
        check("R6 status full+ovf", r, 32'h0000_0887);
        for (int k = 1; k <= DEPTH; k++) begin
            loc_op(1'b1, 3'd3, 32'h0, r);
            check("R6 kept order", r, 32'(k));
        end
        loc_op(1'b1, 3'd3, 32'h0, r);
        check("R5 empty after drain", r, 32'hFFFF_FFFF);
        // R7 wrap-around keeps order
        for (int k = 7; k <= 9; k++) host_op(1'b0, 3'd3, 4'hF, 32'(k), r);
        for (int k = 7; k <= 9; k++) begin
            loc_op(1'b1, 3'd3, 32'h0, r);
            check("R7 wrap order", r, 32'(k));
        end
        loc_op(1'b1, 3'd4, 32'h0, r);
        check("R6 sticky ovf", r, 32'h0000_080F);

        // R9 host push and local pop of empty inbound post, same cycle
        host_addr = 3'd0; host_wdata = 32'h1234_5678; host_be = 4'hF; host_wr = 1'b1;
        loc_addr = 3'd0; loc_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; loc_rd = 1'b0;
        check("R9 bypass data", loc_rdata, 32'h1234_5678);
        check("R9 post queue empty", {31'h0, loc_irq}, 32'h0);

        // R9 host pop first lets local push into full inbound free queue
        for (int k = 0; k < DEPTH; k++) loc_op(1'b0, 3'd1, 32'h40 + 32'(k), r);
        host_addr = 3'd1; host_rd = 1'b1;
        loc_addr = 3'd1; loc_wdata = 32'h0000_0099; loc_wr = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; loc_wr = 1'b0;
        check("R9 host pop first", host_rdata, 32'h0000_0040);
        for (int k = 1; k <= DEPTH; k++) begin
            host_op(1'b1, 3'd1, 4'hF, 32'h0, r);
            exp = (k < DEPTH) ? 32'h40 + 32'(k) : 32'h0000_0099;
            check("R9 accepted push order", r, exp);
        end
        host_op(1'b1, 3'd4, 4'hF, 32'h0, r);
        check("R9 no ovf on q1", r & 32'h0000_0200, 32'h0);

        finish_run();
    end

endmodule